// File: doc/BRIEF.md
# VRAM CPU Access Port

This block is the processor-side access path of a tile-based video renderer. The CPU reaches video memory indirectly. It uses a two-write address register and a data port. A scroll port and a control port share the address register's internal state. A write toggle decides whether a byte lands in the upper or lower half of a temporary address. On the second address write, the temporary address is copied into the current address. Every data-port access then advances the current address by 1 or 32.

The port decides what drives the video memory address bus. Inside the rendering window, the renderer's fetch address drives it. The window runs from dot 1 of the pre-render line until dot 1 of line 240, and it only applies while rendering is enabled. At all other times the current address drives the bus. A data access goes to the on-chip 32-entry palette only when the bus itself carries an address of 0x3F00 or above. As a result, a palette write made while rendering is active is lost, even during horizontal blank. If rendering is switched off mid-frame, the bus falls back to the current address and the palette becomes writable.

Top module: `vram_access_port`

## Requirements
- R1: After reset, the bus address is 0, no memory write strobe is active, the toggle is clear, the increment step is 1 and the bus follows the current address.
- R2: Register selects are 0 control, 1 scroll, 2 address, 3 data, 4 status. An address write with the toggle clear puts data[5:0] into temporary bits 13:8 and leaves the bus address unchanged. With the toggle set, the write puts the byte into temporary bits 7:0 and copies the whole temporary address into the current address, which shows on the bus after that clock edge.
- R3: Scroll writes flip the same toggle as address writes. A status read clears the toggle.
- R4: Each data-port read or write adds 1 to the current address, or 32 when bit 2 of the last control write was 1.
- R5: A data access whose bus address is 0x3F00 or above goes to the palette. A palette write raises no memory write strobe. A palette read returns the 6-bit entry directly, with bits 7:6 zero.
- R6: The palette index is bus bits 4:0. Indices 0x10, 0x14, 0x18 and 0x1C share storage with 0x00, 0x04, 0x08 and 0x0C, and the region repeats every 32 addresses.
- R7: While the rendering window is active and rendering is enabled, the bus carries the fetch address. A data write goes to that fetch address with the write strobe raised, and a palette write requested through the current address is lost.
- R8: The current address still advances on a data access made inside the rendering window.
- R9: A clock with line 240 and dot 1 ends the window, and the bus shows the current address from the next cycle. A clock with line 261 and dot 1 starts the window. Other line/dot pairs leave the window unchanged.
- R10: With rendering disabled, the bus shows the current address at once even inside the window, and palette writes take effect.
- R11: A data read outside the palette returns the byte buffered by the previous data read, then loads the buffer from memory at the current bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | CPU register write strobe |
| regRdEn | input | 1 | CPU register read strobe |
| regSel | input | 3 | Register select (0 control, 1 scroll, 2 address, 3 data, 4 status) |
| cpuWrData | input | 8 | CPU write byte |
| cpuRdData | output | 8 | CPU read byte |
| renderEn | input | 1 | Rendering enable |
| scanline | input | 9 | Current line (261 = pre-render) |
| dot | input | 9 | Current dot in the line |
| fetchAddr | input | 14 | Renderer fetch address |
| busAddr | output | 14 | Video memory bus address |
| vramWe | output | 1 | Video memory write strobe |
| vramWdata | output | 8 | Video memory write byte |
| vramRdata | input | 8 | Video memory read byte for busAddr |

## Verification
Some results follow the strobe within the same cycle: the write strobe, the write byte, the read byte, and the bus address when rendering is switched off. The bench samples these 1 ns after it drives the strobe, before the rising edge. Other results come from a register: the new current address after an address or data access, window entry and exit, palette contents and the read buffer. These show up only after the next rising edge, so the bench samples them on the following falling edge or through a later read. A table walks the address, scroll and status sequences and checks the bus after each step. Directed tests then cover the palette, the window and forced blank.

// File: rtl/vap_pkg.sv
package vap_pkg;
  localparam int BUS_W  = 14;
  localparam int VT_W   = BUS_W + 1;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_SCROLL = 3'd1,
    SEL_ADDR   = 3'd2,
    SEL_DATA   = 3'd3,
    SEL_STATUS = 3'd4
  } vapSel_e;

  typedef struct packed {
    logic ctrlWr;
    logic scrollWr;
    logic addrWr;
    logic dataWr;
    logic dataRd;
    logic statusRd;
    logic palWe;
    logic palRd;
    logic vramWe;
  } vapStrobe_t;
endpackage

// File: rtl/vap_ctrl.sv
module vap_ctrl
  import vap_pkg::*;
#(
  parameter int LINE_W   = 9,
  parameter int DOT_W    = 9,
  parameter int PRE_LINE = 261,
  parameter int END_LINE = 240,
  parameter int PAL_BASE = 'h3F00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regSel,
  input  logic              renderEn,
  input  logic [LINE_W-1:0] scanline,
  input  logic [DOT_W-1:0]  dot,
  input  logic [BUS_W-1:0]  busAddr,
  output logic              fetchMode,
  output logic              winActive,
  output vapStrobe_t        stb
);
  localparam logic [LINE_W-1:0] PRE_L  = LINE_W'(PRE_LINE);
  localparam logic [LINE_W-1:0] END_L  = LINE_W'(END_LINE);
  localparam logic [DOT_W-1:0]  SW_DOT = DOT_W'(1);
  localparam logic [BUS_W-1:0]  PAL_LO = BUS_W'(PAL_BASE);

  logic palHit;
  logic winStart;
  logic winEnd;

  assign winStart = (scanline == PRE_L) && (dot == SW_DOT);
  assign winEnd   = (scanline == END_L) && (dot == SW_DOT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winActive <= 1'b0;
    end else if (winStart) begin
      winActive <= 1'b1;
    end else if (winEnd) begin
      winActive <= 1'b0;
    end
  end

  assign fetchMode = renderEn && winActive;
  assign palHit    = (busAddr >= PAL_LO);

  always_comb begin
    stb          = '0;
    stb.ctrlWr   = regWrEn && (regSel == SEL_CTRL);
    stb.scrollWr = regWrEn && (regSel == SEL_SCROLL);
    stb.addrWr   = regWrEn && (regSel == SEL_ADDR);
    stb.dataWr   = regWrEn && (regSel == SEL_DATA);
    stb.dataRd   = regRdEn && (regSel == SEL_DATA);
    stb.statusRd = regRdEn && (regSel == SEL_STATUS);
    stb.palWe    = stb.dataWr && palHit;
    stb.palRd    = stb.dataRd && palHit;
    stb.vramWe   = stb.dataWr && !palHit;
  end
endmodule

// File: rtl/vap_datapath.sv
module vap_datapath
  import vap_pkg::*;
#(
  parameter int PAL_DEPTH = 32,
  parameter int PAL_W     = 6,
  parameter int STEP_BIG  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  vapStrobe_t        stb,
  input  logic              fetchMode,
  input  logic [BYTE_W-1:0] cpuWrData,
  input  logic [BUS_W-1:0]  fetchAddr,
  input  logic [BYTE_W-1:0] vramRdata,
  output logic [BUS_W-1:0]  busAddr,
  output logic [BYTE_W-1:0] cpuRdData,
  output logic [BYTE_W-1:0] vramWdata,
  output logic              writeToggle,
  output logic              incBig,
  output logic [VT_W-1:0]   vAddr,
  output logic [VT_W-1:0]   tAddr
);
  localparam int IDX_W = $clog2(PAL_DEPTH);
  localparam logic [VT_W-1:0] STEP_ONE = VT_W'(1);
  localparam logic [VT_W-1:0] STEP_WIDE = VT_W'(STEP_BIG);

  logic [PAL_W-1:0]  palMem [PAL_DEPTH];
  logic [BYTE_W-1:0] readBuf;
  logic [IDX_W-1:0]  palIdx;
  logic [VT_W-1:0]   step;

  always_comb begin
    palIdx = busAddr[IDX_W-1:0];
    if (palIdx[1:0] == 2'b00) begin
      palIdx[IDX_W-1] = 1'b0;
    end
  end

  assign busAddr   = fetchMode ? fetchAddr : vAddr[BUS_W-1:0];
  assign step      = incBig ? STEP_WIDE : STEP_ONE;
  assign vramWdata = stb.vramWe ? cpuWrData : '0;

  always_comb begin
    cpuRdData = '0;
    if (stb.dataRd) begin
      if (stb.palRd) begin
        cpuRdData = BYTE_W'(palMem[palIdx]);
      end else begin
        cpuRdData = readBuf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vAddr       <= '0;
      tAddr       <= '0;
      writeToggle <= 1'b0;
      incBig      <= 1'b0;
      readBuf     <= '0;
    end else begin
      if (stb.ctrlWr) begin
        incBig       <= cpuWrData[2];
        tAddr[11:10] <= cpuWrData[1:0];
      end
      if (stb.statusRd) begin
        writeToggle <= 1'b0;
      end
      if (stb.scrollWr) begin
        if (!writeToggle) begin
          tAddr[4:0] <= cpuWrData[7:3];
        end else begin
          tAddr[14:12] <= cpuWrData[2:0];
          tAddr[9:5]   <= cpuWrData[7:3];
        end
        writeToggle <= !writeToggle;
      end
      if (stb.addrWr) begin
        if (!writeToggle) begin
          tAddr[14]   <= 1'b0;
          tAddr[13:8] <= cpuWrData[5:0];
        end else begin
          tAddr[7:0] <= cpuWrData;
          vAddr      <= {tAddr[14:8], cpuWrData};
        end
        writeToggle <= !writeToggle;
      end
      if (stb.dataWr || stb.dataRd) begin
        vAddr <= vAddr + step;
      end
      if (stb.dataRd) begin
        readBuf <= vramRdata;
      end
    end
  end

  generate
    for (genvar gi = 0; gi < PAL_DEPTH; gi++) begin : g_pal
      always_ff @(posedge clk) begin
        if (!rstN) begin
          palMem[gi] <= '0;
        end else if (stb.palWe && (palIdx == IDX_W'(gi))) begin
          palMem[gi] <= cpuWrData[PAL_W-1:0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/vram_access_port.sv
module vram_access_port
  import vap_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int DOT_W     = 9,
  parameter int PRE_LINE  = 261,
  parameter int END_LINE  = 240,
  parameter int PAL_DEPTH = 32,
  parameter int PAL_W     = 6,
  parameter int STEP_BIG  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regSel,
  input  logic [7:0]        cpuWrData,
  output logic [7:0]        cpuRdData,
  input  logic              renderEn,
  input  logic [LINE_W-1:0] scanline,
  input  logic [DOT_W-1:0]  dot,
  input  logic [13:0]       fetchAddr,
  output logic [13:0]       busAddr,
  output logic              vramWe,
  output logic [7:0]        vramWdata,
  input  logic [7:0]        vramRdata
);
  vapStrobe_t      stb;
  logic            fetchMode;
  logic            winActive;
  logic            writeToggle;
  logic            incBig;
  logic [VT_W-1:0] vAddr;
  logic [VT_W-1:0] tAddr;

  vap_ctrl #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .PRE_LINE(PRE_LINE),
    .END_LINE(END_LINE), .PAL_BASE('h3F00)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .renderEn(renderEn), .scanline(scanline), .dot(dot),
    .busAddr(busAddr), .fetchMode(fetchMode), .winActive(winActive), .stb(stb)
  );

  vap_datapath #(
    .PAL_DEPTH(PAL_DEPTH), .PAL_W(PAL_W), .STEP_BIG(STEP_BIG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fetchMode(fetchMode),
    .cpuWrData(cpuWrData), .fetchAddr(fetchAddr), .vramRdata(vramRdata),
    .busAddr(busAddr), .cpuRdData(cpuRdData), .vramWdata(vramWdata),
    .writeToggle(writeToggle), .incBig(incBig), .vAddr(vAddr), .tAddr(tAddr)
  );

  assign vramWe = stb.vramWe;
endmodule

// File: rtl/vap_checker.sv
module vap_checker
  import vap_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int DOT_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input vapStrobe_t        stb,
  input logic              fetchMode,
  input logic              winActive,
  input logic              renderEn,
  input logic [BUS_W-1:0]  busAddr,
  input logic [BUS_W-1:0]  fetchAddr,
  input logic [VT_W-1:0]   vAddr,
  input logic [VT_W-1:0]   tAddr,
  input logic              writeToggle,
  input logic              incBig,
  input logic [BYTE_W-1:0] cpuWrData,
  input logic [LINE_W-1:0] scanline,
  input logic [DOT_W-1:0]  dot
);
  p_second_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrWr && writeToggle) |=> (vAddr == {$past(tAddr[14:8]), $past(cpuWrData)}));

  p_status_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statusRd && !stb.addrWr && !stb.scrollWr) |=> !writeToggle);

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataWr || stb.dataRd) |=>
      (vAddr == $past(vAddr) + ($past(incBig) ? VT_W'(32) : VT_W'(1))));

  p_pal_no_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.palWe |-> !stb.vramWe);

  p_no_pal_in_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fetchMode && (fetchAddr < 14'h3000)) |-> !stb.palWe);

  p_window_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((scanline == LINE_W'(240)) && (dot == DOT_W'(1))) |=> !winActive);

  p_forced_blank_r10: assert property (@(posedge clk) disable iff (!rstN)
    !renderEn |-> (busAddr == vAddr[BUS_W-1:0]));
endmodule

bind vram_access_port vap_checker #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .fetchMode(fetchMode),
  .winActive(winActive), .renderEn(renderEn), .busAddr(busAddr),
  .fetchAddr(fetchAddr), .vAddr(vAddr), .tAddr(tAddr),
  .writeToggle(writeToggle), .incBig(incBig), .cpuWrData(cpuWrData),
  .scanline(scanline), .dot(dot)
);

// File: tb/vram_access_port_test.sv
module vram_access_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [7:0] cpuWrData = 8'd0;
  logic [7:0] cpuRdData;
  logic       renderEn = 1'b0;
  logic [8:0] scanline = 9'd100;
  logic [8:0] dot = 9'd50;
  logic [13:0] fetchAddr = 14'h0ABC;
  logic [13:0] busAddr;
  logic       vramWe;
  logic [7:0] vramWdata;
  logic [7:0] vramRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       wrWe;
  logic [13:0] wrBus;
  logic [7:0] wrData;
  logic [7:0] rd;

  always #2 clk = ~clk;

  assign vramRdata = busAddr[7:0] ^ {2'b00, busAddr[13:8]};

  vram_access_port uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .renderEn(renderEn), .scanline(scanline), .dot(dot),
    .fetchAddr(fetchAddr), .busAddr(busAddr), .vramWe(vramWe),
    .vramWdata(vramWdata), .vramRdata(vramRdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; cpuWrData = d; regWrEn = 1'b1;
    #1;
    wrWe = vramWe; wrBus = busAddr; wrData = vramWdata;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; regRdEn = 1'b1;
    #1 d = cpuRdData;
    @(posedge clk);
    #1 regRdEn = 1'b0;
  endtask

  task automatic setAddr(input logic [15:0] a);
    regWr(3'd2, a[15:8]);
    regWr(3'd2, a[7:0]);
  endtask

  task automatic pulseLine(input logic [8:0] ln, input logic [8:0] dt);
    @(negedge clk);
    scanline = ln; dot = dt;
    @(posedge clk);
    #1 scanline = 9'd100; dot = 9'd50;
  endtask

  // {isRead, sel, data, expected bus after}
  localparam logic [27:0] VEC [11] = '{
    {1'b0, 3'd2, 8'h21, 16'h0000},
    {1'b0, 3'd2, 8'h08, 16'h2108},
    {1'b0, 3'd1, 8'h00, 16'h2108},
    {1'b0, 3'd2, 8'h55, 16'h2155},
    {1'b0, 3'd2, 8'h3F, 16'h2155},
    {1'b1, 3'd4, 8'h00, 16'h2155},
    {1'b0, 3'd2, 8'h23, 16'h2155},
    {1'b0, 3'd2, 8'h00, 16'h2300},
    {1'b0, 3'd3, 8'h11, 16'h2301},
    {1'b0, 3'd0, 8'h04, 16'h2301},
    {1'b0, 3'd3, 8'h22, 16'h2321}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 bus", 32'(busAddr), 32'h0);
    chk("R1 we", 32'(vramWe), 32'h0);

    // table: R2 address pair, R3 shared toggle/status clear, R4 step
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][27]) regRd(VEC[i][26:24], rd);
      else regWr(VEC[i][26:24], VEC[i][23:16]);
      @(negedge clk);
      chk($sformatf("R2/R3/R4 vec %0d", i), 32'(busAddr), 32'(VEC[i][13:0]));
    end
    regWr(3'd0, 8'h00);

    // R5 palette write/read
    setAddr(16'h3F01);
    regWr(3'd3, 8'hEA);
    chk("R5 no strobe", 32'(wrWe), 32'h0);
    setAddr(16'h3F01);
    regRd(3'd3, rd);
    chk("R5 read direct", 32'(rd), 32'h2A);

    // R6 mirrors
    setAddr(16'h3F10);
    regWr(3'd3, 8'h15);
    setAddr(16'h3F00);
    regRd(3'd3, rd);
    chk("R6 0x10 mirrors 0x00", 32'(rd), 32'h15);
    setAddr(16'h3F04);
    regWr(3'd3, 8'h07);
    setAddr(16'h3F24);
    regRd(3'd3, rd);
    chk("R6 repeat 32", 32'(rd), 32'h07);
    setAddr(16'h3F11);
    regWr(3'd3, 8'h33);
    setAddr(16'h3F01);
    regRd(3'd3, rd);
    chk("R6 0x11 separate", 32'(rd), 32'h2A);

    // R11 buffered reads
    setAddr(16'h2010);
    regRd(3'd3, rd);
    regRd(3'd3, rd);
    chk("R11 buffered", 32'(rd), 32'h30);
    regRd(3'd3, rd);
    chk("R11 next", 32'(rd), 32'h31);

    // R7 / R8 / R9 rendering window
    setAddr(16'h3F02);
    renderEn = 1'b1;
    pulseLine(9'd261, 9'd1);
    @(negedge clk);
    chk("R7 fetch on bus", 32'(busAddr), 32'h0ABC);
    regWr(3'd3, 8'h3C);
    chk("R7 write strobe", 32'(wrWe), 32'h1);
    chk("R7 write addr", 32'(wrBus), 32'h0ABC);
    chk("R7 write data", 32'(wrData), 32'h3C);
    pulseLine(9'd240, 9'd0);
    @(negedge clk);
    chk("R9 no exit dot0", 32'(busAddr), 32'h0ABC);
    pulseLine(9'd240, 9'd1);
    @(negedge clk);
    chk("R9 exit / R8 incremented", 32'(busAddr), 32'h3F03);
    setAddr(16'h3F02);
    regRd(3'd3, rd);
    chk("R7 palette write lost", 32'(rd), 32'h00);

    // R10 forced blank
    pulseLine(9'd261, 9'd1);
    @(negedge clk);
    chk("R9 window start", 32'(busAddr), 32'h0ABC);
    renderEn = 1'b0;
    #1 chk("R10 bus shows v", 32'(busAddr), 32'h3F03);
    setAddr(16'h3F05);
    regWr(3'd3, 8'h19);
    chk("R10 palette no strobe", 32'(wrWe), 32'h0);
    @(negedge clk);
    renderEn = 1'b1;
    #1 chk("R10 fetch returns", 32'(busAddr), 32'h0ABC);
    renderEn = 1'b0;
    pulseLine(9'd240, 9'd1);
    setAddr(16'h3F05);
    regRd(3'd3, rd);
    chk("R10 palette written", 32'(rd), 32'h19);

    // R1 reset state again
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 bus after reset", 32'(busAddr), 32'h0);
    regWr(3'd2, 8'h12);
    regWr(3'd2, 8'h34);
    regWr(3'd3, 8'h00);
    @(negedge clk);
    chk("R1 toggle and step reset", 32'(busAddr), 32'h1235);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule